// File: doc/BRIEF.md
# DRAM Strobe Decoder with Refresh Counter

This block is the control section of an asynchronous page-mode DRAM device, rebuilt as synchronous logic that samples the four active-low strobes (row strobe, column strobe, write enable, output enable) and the address bus on a fast clock. From the order in which the strobes move, it decides whether a normal access, a row-only refresh, a column-before-row refresh or a self-refresh episode is under way. It then issues one-cycle internal strobes to latch a row, latch a column, read or write, and refresh a row. It also keeps a level that tells the output drivers when to drive.

Refresh cycles that start with the column strobe already low take their row from an internal counter. That counter steps by `ROWS_PER_CBR` rows per refresh, so a two-row organisation covers its array in half as many refresh cycles. If the row strobe is held low long enough after such an entry, the block enters self refresh. There it refreshes rows on its own timer until the row strobe rises, and it finishes any internal refresh still in flight before it returns to idle. The block is meant to stand in for the device's control logic in a self-checking environment; the storage array and analog buffers sit outside it.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: A row-strobe fall with the column strobe high pulses `row_stb` and latches the address into `row_addr`. Each later column-strobe fall while the row strobe stays low pulses `col_stb` and latches the address into `col_addr` (page mode).
- R2: At a column-strobe fall, write enable high gives `rd_stb` and write enable low gives `wr_stb` (early write). A write-enable fall while the column strobe is low after a column latch gives `wr_stb` (late write).
- R3: A row-strobe fall and rise with no column-strobe fall in between pulses `ref_stb` at the rise, with `ref_row` equal to the latched row address.
- R4: When the column strobe is already low as the row strobe falls, `ref_stb` pulses with `ref_row` equal to the internal counter, no `row_stb` is issued, `cyc_kind` reads 2 while the row strobe stays low, and the counter then advances by `ROWS_PER_CBR`.
- R5: The refresh counter starts at 0, wraps to 0 after 2^ROW_BITS / ROWS_PER_CBR advances, and is cleared only by `rst`.
- R6: A row strobe held low for `SELF_ENTRY_CYCLES` clocks after a counter-refresh entry sets `cyc_kind` to 3 (self refresh). Self refresh is entered from no other state.
- R7: In self refresh, an internal tick every `SELF_TICK_CYCLES` clocks pulses `ref_stb` with the counter value and advances the counter.
- R8: A row-strobe rise in self refresh returns `cyc_kind` to 0 at once when no tick is in flight. Otherwise `cyc_kind` reads 4 (drain) until the `TICK_BUSY` clocks of that tick have elapsed, and then reads 0.
- R9: `dq_drive` is 0 whenever the column strobe is high, whatever the output enable does.
- R10: After a read column latch, `dq_drive` is 1 while the column strobe and the output enable are both low. Raising the output enable turns it off, and lowering it again before the column strobe rises drives the same read data again.
- R11: A write (early or late) leaves `dq_drive` at 0 for the rest of that column cycle, even with the output enable low.
- R12: A column strobe held low across a row-strobe rise and a new fall (hidden refresh) keeps the prior read data driven while the new cycle is classified as a counter refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| row_stb | output | 1 | One-cycle row-latch strobe |
| row_addr | output | ROW_BITS | Latched row address |
| col_stb | output | 1 | One-cycle column-latch strobe |
| col_addr | output | COL_BITS | Latched column address |
| rd_stb | output | 1 | One-cycle read request |
| wr_stb | output | 1 | One-cycle write request |
| ref_stb | output | 1 | One-cycle refresh request |
| ref_row | output | ROW_BITS | Row to refresh (first of `ROWS_PER_CBR` for counter refreshes) |
| dq_drive | output | 1 | Output-driver enable level |
| cyc_kind | output | 3 | 0 idle, 1 access, 2 counter refresh, 3 self refresh, 4 self-refresh drain |

## Verification
The assertions assume that every strobe and address level stays stable for at least two sampling clocks, so that each edge is seen once and the address is valid on the clock where its strobe edge is detected. They also assume that write enable only falls while the column strobe is low, or is already low before it. The bench drives every input on the falling clock edge, holds each level for three or more clocks, and changes the address only while the strobes are steady. It counts strobes on a monitor that samples well after each rising edge. Self-refresh tick counts are compared against a window of one tick either way, because entry and tick phase depend on where the hold started.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        KIND_IDLE   = 3'd0,
        KIND_ACCESS = 3'd1,
        KIND_CBR    = 3'd2,
        KIND_SELF   = 3'd3,
        KIND_DRAIN  = 3'd4
    } cyc_kind_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } pin_lvl_s;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic we_fall;
    } pin_edge_s;

    // width of a counter that must hold values 0..n
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/dsc_pin_sampler.sv
module dsc_pin_sampler
    import dsc_pkg::*;
#(
    parameter int ADDR_BITS = 13
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic [ADDR_BITS-1:0] addr,
    output pin_lvl_s             lvl,
    output pin_edge_s            edg,
    output logic [ADDR_BITS-1:0] addr_q
);

    logic prev_ras, prev_cas, prev_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl      <= '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
            prev_ras <= 1'b1;
            prev_cas <= 1'b1;
            prev_we  <= 1'b1;
            addr_q   <= '0;
        end else begin
            lvl      <= '{ras_n: ras_n, cas_n: cas_n, we_n: we_n, oe_n: oe_n};
            prev_ras <= lvl.ras_n;
            prev_cas <= lvl.cas_n;
            prev_we  <= lvl.we_n;
            addr_q   <= addr;
        end
    end

    always_comb begin
        edg.ras_fall = prev_ras & ~lvl.ras_n;
        edg.ras_rise = ~prev_ras & lvl.ras_n;
        edg.cas_fall = prev_cas & ~lvl.cas_n;
        edg.we_fall  = prev_we & ~lvl.we_n;
    end

endmodule

// File: rtl/dsc_refresh_counter.sv
module dsc_refresh_counter #(
    parameter int ROW_BITS     = 13,
    parameter int ROWS_PER_CBR = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    output logic [ROW_BITS-1:0] cnt
);

    localparam logic [ROW_BITS-1:0] STEP = ROW_BITS'(ROWS_PER_CBR);

    // power-of-two row count: natural overflow lands exactly on zero
    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (adv) cnt <= cnt + STEP;
    end

    AST_COUNT_STEP:  assert property (@(posedge clk) disable iff (rst)
        adv |=> (cnt == $past(cnt) + STEP));                        // R5
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));                                     // R5

endmodule

// File: rtl/dsc_cycle_fsm.sv
module dsc_cycle_fsm
    import dsc_pkg::*;
#(
    parameter int ROW_BITS          = 13,
    parameter int COL_BITS          = 11,
    parameter int ADDR_BITS         = 13,
    parameter int SELF_ENTRY_CYCLES = 10000,
    parameter int SELF_TICK_CYCLES  = 1563,
    parameter int TICK_BUSY         = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_lvl_s             lvl,
    input  pin_edge_s            edg,
    input  logic [ADDR_BITS-1:0] addr_q,
    input  logic [ROW_BITS-1:0]  cnt,
    output logic                 adv,
    output logic                 row_stb,
    output logic [ROW_BITS-1:0]  row_addr,
    output logic                 col_stb,
    output logic [COL_BITS-1:0]  col_addr,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic                 ref_stb,
    output logic [ROW_BITS-1:0]  ref_row,
    output cyc_kind_e            kind
);

    localparam int HOLD_W = cnt_w(SELF_ENTRY_CYCLES);
    localparam int TMR_W  = cnt_w(SELF_TICK_CYCLES);
    localparam int BUSY_W = cnt_w(TICK_BUSY);

    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(SELF_ENTRY_CYCLES - 1);
    localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(SELF_TICK_CYCLES - 1);
    localparam logic [BUSY_W-1:0] BUSY_LEN  = BUSY_W'(TICK_BUSY);

    logic [HOLD_W-1:0] hold;
    logic [TMR_W-1:0]  tmr;
    logic [BUSY_W-1:0] busy;
    logic              got_col;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind     <= KIND_IDLE;
            adv      <= 1'b0;
            row_stb  <= 1'b0;
            col_stb  <= 1'b0;
            rd_stb   <= 1'b0;
            wr_stb   <= 1'b0;
            ref_stb  <= 1'b0;
            row_addr <= '0;
            col_addr <= '0;
            ref_row  <= '0;
            hold     <= '0;
            tmr      <= '0;
            busy     <= '0;
            got_col  <= 1'b0;
        end else begin
            adv     <= 1'b0;
            row_stb <= 1'b0;
            col_stb <= 1'b0;
            rd_stb  <= 1'b0;
            wr_stb  <= 1'b0;
            ref_stb <= 1'b0;
            if (busy != '0) busy <= busy - 1'b1;

            case (kind)
                KIND_IDLE: begin
                    if (edg.ras_fall) begin
                        if (!lvl.cas_n) begin
                            // column strobe first: counter-driven refresh
                            kind    <= KIND_CBR;
                            ref_stb <= 1'b1;
                            ref_row <= cnt;
                            adv     <= 1'b1;
                            hold    <= '0;
                        end else begin
                            kind     <= KIND_ACCESS;
                            row_stb  <= 1'b1;
                            row_addr <= addr_q[ROW_BITS-1:0];
                            got_col  <= 1'b0;
                        end
                    end
                end
                KIND_ACCESS: begin
                    if (edg.ras_rise) begin
                        kind <= KIND_IDLE;
                        if (!got_col) begin
                            ref_stb <= 1'b1;
                            ref_row <= row_addr;
                        end
                    end else if (edg.cas_fall) begin
                        col_stb  <= 1'b1;
                        col_addr <= addr_q[COL_BITS-1:0];
                        got_col  <= 1'b1;
                        if (!lvl.we_n) wr_stb <= 1'b1;
                        else           rd_stb <= 1'b1;
                    end else if (edg.we_fall && !lvl.cas_n && got_col) begin
                        wr_stb <= 1'b1;
                    end
                end
                KIND_CBR: begin
                    if (edg.ras_rise) begin
                        kind <= KIND_IDLE;
                    end else if (hold == HOLD_LAST) begin
                        kind <= KIND_SELF;
                        tmr  <= '0;
                    end else begin
                        hold <= hold + 1'b1;
                    end
                end
                KIND_SELF: begin
                    if (edg.ras_rise) begin
                        kind <= (busy != '0) ? KIND_DRAIN : KIND_IDLE;
                    end else if (tmr == TMR_LAST) begin
                        tmr     <= '0;
                        ref_stb <= 1'b1;
                        ref_row <= cnt;
                        adv     <= 1'b1;
                        busy    <= BUSY_LEN;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                KIND_DRAIN: begin
                    if (busy == '0) kind <= KIND_IDLE;
                end
                default: kind <= KIND_IDLE;
            endcase
        end
    end

    AST_ONE_LATCH_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({row_stb, col_stb, ref_stb}));                     // R1
    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));                                       // R2
    AST_CBR_NO_ROW_LATCH: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_CBR) |-> !row_stb);                           // R4
    AST_SELF_FROM_CBR: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_SELF && $past(kind) != KIND_SELF) |-> ($past(kind) == KIND_CBR)); // R6
    AST_DRAIN_FROM_SELF: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_DRAIN && $past(kind) != KIND_DRAIN) |-> ($past(kind) == KIND_SELF)); // R8

endmodule

// File: rtl/dsc_output_ctl.sv
module dsc_output_ctl
    import dsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_lvl_s lvl,
    input  logic     rd_stb,
    input  logic     wr_stb,
    output logic     dq_drive
);

    logic data_valid;

    // read data is held only while the column strobe stays low
    always_ff @(posedge clk) begin
        if (rst)                       data_valid <= 1'b0;
        else if (lvl.cas_n || wr_stb)  data_valid <= 1'b0;
        else if (rd_stb)               data_valid <= 1'b1;
    end

    assign dq_drive = data_valid & ~lvl.cas_n & ~lvl.oe_n;

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_drive) |-> !lvl.oe_n);                             // R10

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
    import dsc_pkg::*;
#(
    parameter int ROW_BITS          = 13,
    parameter int COL_BITS          = 11,
    parameter int ROWS_PER_CBR      = 2,
    parameter int SELF_ENTRY_CYCLES = 10000,
    parameter int SELF_TICK_CYCLES  = 1563,
    parameter int TICK_BUSY         = 8,
    localparam int ADDR_BITS        = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic [ADDR_BITS-1:0] addr,
    output logic                 row_stb,
    output logic [ROW_BITS-1:0]  row_addr,
    output logic                 col_stb,
    output logic [COL_BITS-1:0]  col_addr,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic                 ref_stb,
    output logic [ROW_BITS-1:0]  ref_row,
    output logic                 dq_drive,
    output logic [2:0]           cyc_kind
);

    pin_lvl_s              lvl;
    pin_edge_s             edg;
    logic [ADDR_BITS-1:0]  addr_q;
    logic [ROW_BITS-1:0]   cnt;
    logic                  adv;
    cyc_kind_e             kind;

    dsc_pin_sampler #(.ADDR_BITS(ADDR_BITS)) u_sampler (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .lvl(lvl), .edg(edg), .addr_q(addr_q)
    );

    dsc_refresh_counter #(.ROW_BITS(ROW_BITS), .ROWS_PER_CBR(ROWS_PER_CBR)) u_counter (
        .clk(clk), .rst(rst), .adv(adv), .cnt(cnt)
    );

    dsc_cycle_fsm #(
        .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .ADDR_BITS(ADDR_BITS),
        .SELF_ENTRY_CYCLES(SELF_ENTRY_CYCLES), .SELF_TICK_CYCLES(SELF_TICK_CYCLES),
        .TICK_BUSY(TICK_BUSY)
    ) u_fsm (
        .clk(clk), .rst(rst), .lvl(lvl), .edg(edg), .addr_q(addr_q), .cnt(cnt),
        .adv(adv), .row_stb(row_stb), .row_addr(row_addr), .col_stb(col_stb),
        .col_addr(col_addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .ref_stb(ref_stb),
        .ref_row(ref_row), .kind(kind)
    );

    dsc_output_ctl u_outctl (
        .clk(clk), .rst(rst), .lvl(lvl), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .dq_drive(dq_drive)
    );

    assign cyc_kind = kind;

    AST_OPEN_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cas_n && $past(cas_n)) |-> !dq_drive);                     // R9
    AST_WRITE_OPENS: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !dq_drive);                                      // R11

endmodule

// File: tb/tb_dram_strobe_ctrl.sv
module tb_dram_strobe_ctrl;

    localparam int CLK_P  = 10;
    localparam int RB     = 4;
    localparam int CB     = 3;
    localparam int STEP   = 2;
    localparam int ENTRY  = 20;
    localparam int TICKP  = 10;
    localparam int BUSY   = 6;
    localparam int AB     = (RB > CB) ? RB : CB;
    localparam int ROWS   = 1 << RB;

    logic clk = 1'b0, rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AB-1:0] addr = '0;
    logic row_stb, col_stb, rd_stb, wr_stb, ref_stb, dq_drive;
    logic [RB-1:0] row_addr, ref_row;
    logic [CB-1:0] col_addr;
    logic [2:0] cyc_kind;

    int errs = 0, checks = 0;
    int n_row = 0, n_col = 0, n_rd = 0, n_wr = 0, n_ref = 0, n_drain = 0;
    int last_row = 0, last_col = 0, last_ref = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dram_strobe_ctrl #(
        .ROW_BITS(RB), .COL_BITS(CB), .ROWS_PER_CBR(STEP),
        .SELF_ENTRY_CYCLES(ENTRY), .SELF_TICK_CYCLES(TICK_P_FIX(TICKP)), .TICK_BUSY(BUSY)
    ) dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .row_stb(row_stb), .row_addr(row_addr), .col_stb(col_stb),
        .col_addr(col_addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .ref_stb(ref_stb),
        .ref_row(ref_row), .dq_drive(dq_drive), .cyc_kind(cyc_kind)
    );

    function automatic int TICK_P_FIX(input int v);
        return v;
    endfunction

    // monitor: samples 2 time units after each rising edge
    always begin
        @(posedge clk);
        #2;
        if (row_stb) begin n_row++; last_row = int'(row_addr); end
        if (col_stb) begin n_col++; last_col = int'(col_addr); end
        if (rd_stb)  n_rd++;
        if (wr_stb)  n_wr++;
        if (ref_stb) begin n_ref++; last_ref = int'(ref_row); end
        if (cyc_kind == 3'd4) n_drain++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_cbr();
        int r0, w0;
        r0 = n_ref; w0 = n_row;
        cas_n = 1'b0; tick(2);
        ras_n = 1'b0; tick(4);
        chk(n_ref == r0 + 1, "R4 ref strobe count", n_ref - r0, 1);
        chk(last_ref == exp_cnt, "R4/R5 ref_row from counter", last_ref, exp_cnt);
        chk(n_row == w0, "R4 no row latch", n_row - w0, 0);
        chk(cyc_kind == 3'd2, "R4 kind", int'(cyc_kind), 2);
        exp_cnt = (exp_cnt + STEP) % ROWS;
        ras_n = 1'b1; tick(2);
        cas_n = 1'b1; tick(3);
    endtask

    task automatic open_read(input int row, input int col);
        addr = AB'(row); ras_n = 1'b0; tick(3);
        addr = AB'(col); we_n = 1'b1; cas_n = 1'b0; tick(4);
    endtask

    task automatic self_episode(input bit drain_case);
        int r0, ticks, k;
        r0 = n_ref;
        cas_n = 1'b0; tick(2);
        ras_n = 1'b0; tick(ENTRY + 5);
        chk(cyc_kind == 3'd3, "R6 self refresh entered", int'(cyc_kind), 3);
        tick(5 * TICKP);
        ticks = n_ref - r0 - 1;
        chk(ticks >= 4 && ticks <= 6, "R7 tick count in window", ticks, 5);
        k = 0;
        while (!ref_stb && k < 4 * TICKP) begin tick(1); k++; end
        if (!drain_case) tick(7);
        n_drain = 0;
        ras_n = 1'b1;
        if (drain_case) begin
            tick(2);
            chk(cyc_kind == 3'd4, "R8 drain while tick busy", int'(cyc_kind), 4);
            tick(8);
            chk(cyc_kind == 3'd0, "R8 idle after drain", int'(cyc_kind), 0);
        end else begin
            tick(3);
            chk(cyc_kind == 3'd0, "R8 direct idle", int'(cyc_kind), 0);
            chk(n_drain == 0, "R8 no drain when idle tick", n_drain, 0);
        end
        cas_n = 1'b1; tick(3);
        ticks = n_ref - r0 - 1;
        exp_cnt = (exp_cnt + STEP * (1 + ticks)) % ROWS;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int r0, c0, d0, w0;
        tick(4); rst = 1'b0; tick(2);
        // reset state (R5, R9)
        chk(cyc_kind == 3'd0, "R5 reset kind", int'(cyc_kind), 0);
        chk(dq_drive == 1'b0, "R9 reset dq_drive", int'(dq_drive), 0);
        chk(ref_row == '0, "R5 reset ref_row", int'(ref_row), 0);

        // R1/R2: sweep every row and column in page mode
        for (int r = 0; r < ROWS; r++) begin
            w0 = n_row;
            addr = AB'(r); ras_n = 1'b0; tick(3);
            chk(n_row == w0 + 1 && last_row == r, "R1 row latch", last_row, r);
            chk(cyc_kind == 3'd1, "R1 access kind", int'(cyc_kind), 1);
            for (int c = 0; c < (1 << CB); c++) begin
                c0 = n_col; r0 = n_rd; d0 = n_wr;
                addr = AB'(c); we_n = ~c[0]; cas_n = 1'b0; tick(4);
                chk(n_col == c0 + 1 && last_col == c, "R1 column latch", last_col, c);
                if (c[0]) chk(n_wr == d0 + 1 && n_rd == r0, "R2 early write strobe", n_wr - d0, 1);
                else      chk(n_rd == r0 + 1 && n_wr == d0, "R2 read strobe", n_rd - r0, 1);
                cas_n = 1'b1; we_n = 1'b1; tick(3);
            end
            r0 = n_ref;
            ras_n = 1'b1; tick(3);
            chk(n_ref == r0, "R3 no refresh after access", n_ref - r0, 0);
        end

        // R9/R10: output enable corner cases on a read
        oe_n = 1'b0; addr = AB'(3); ras_n = 1'b0; tick(3);
        chk(dq_drive == 1'b0, "R9 open before column", int'(dq_drive), 0);
        addr = AB'(2); cas_n = 1'b0; tick(4);
        chk(dq_drive == 1'b1, "R10 read drives", int'(dq_drive), 1);
        oe_n = 1'b1; tick(3);
        chk(dq_drive == 1'b0, "R10 oe high opens", int'(dq_drive), 0);
        oe_n = 1'b0; tick(3);
        chk(dq_drive == 1'b1, "R10 oe low drives again", int'(dq_drive), 1);
        cas_n = 1'b1; tick(3);
        chk(dq_drive == 1'b0, "R9 cas high opens with oe low", int'(dq_drive), 0);
        ras_n = 1'b1; tick(3);

        // R11: early write with oe low
        addr = AB'(6); ras_n = 1'b0; tick(3);
        we_n = 1'b0; tick(2);
        addr = AB'(1); cas_n = 1'b0; tick(4);
        chk(dq_drive == 1'b0, "R11 early write open", int'(dq_drive), 0);
        tick(5);
        chk(dq_drive == 1'b0, "R11 still open", int'(dq_drive), 0);
        cas_n = 1'b1; we_n = 1'b1; tick(3);
        ras_n = 1'b1; tick(3);

        // R2/R11: late write after a read
        d0 = n_wr;
        open_read(7, 5);
        chk(dq_drive == 1'b1, "R10 read before late write", int'(dq_drive), 1);
        we_n = 1'b0; tick(4);
        chk(n_wr == d0 + 1, "R2 late write strobe", n_wr - d0, 1);
        chk(dq_drive == 1'b0, "R11 late write opens", int'(dq_drive), 0);
        cas_n = 1'b1; we_n = 1'b1; tick(3);
        ras_n = 1'b1; tick(3);

        // R3: row-only refresh
        for (int r = 1; r < ROWS; r += 5) begin
            r0 = n_ref;
            addr = AB'(r); ras_n = 1'b0; tick(3);
            ras_n = 1'b1; tick(3);
            chk(n_ref == r0 + 1 && last_ref == r, "R3 row-only refresh row", last_ref, r);
        end

        // R4/R5: counter refresh across the wrap
        for (int i = 0; i < ROWS / STEP + 2; i++) do_cbr();

        // R12: hidden refresh keeps read data
        open_read(4, 3);
        chk(dq_drive == 1'b1, "R12 drive before hidden refresh", int'(dq_drive), 1);
        ras_n = 1'b1; tick(3);
        r0 = n_ref;
        ras_n = 1'b0; tick(4);
        chk(n_ref == r0 + 1 && last_ref == exp_cnt, "R12 hidden refresh row", last_ref, exp_cnt);
        chk(cyc_kind == 3'd2, "R12 kind counter refresh", int'(cyc_kind), 2);
        chk(dq_drive == 1'b1, "R12 data held", int'(dq_drive), 1);
        exp_cnt = (exp_cnt + STEP) % ROWS;
        ras_n = 1'b1; tick(3);
        cas_n = 1'b1; tick(3);
        chk(dq_drive == 1'b0, "R9 open after hidden refresh", int'(dq_drive), 0);
        oe_n = 1'b1;

        // R6/R7/R8: self refresh, both exit paths
        self_episode(1'b1);
        do_cbr();
        self_episode(1'b0);
        do_cbr();

        // R5: reset clears the counter
        rst = 1'b1; tick(2); rst = 1'b0; tick(2);
        exp_cnt = 0;
        do_cbr();
        do_cbr();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule